// File: doc/BRIEF.md
# Memory Fence Decode and Pause Unit

This block sits next to the decode stage of an in-order core and looks at the memory-ordering instruction class. Each valid instruction word is checked for the ordering opcode. When the word is a fence, the block produces the effective predecessor and successor ordering sets and raises a fence request for the memory pipeline. Before these sets go out, device input and output ordering bits can be widened into memory read and write ordering. This depends on the current privilege mode and on the three environment-configuration enables that treat device I/O as memory.

One exact encoding is the pause hint. It raises no fence request and carries no ordering. Instead it loads a bounded stall timer, and the timer holds retirement through `stall_o`. The stall ends when the timer expires, or earlier when the memory side reports that no transactions are outstanding. The decode outputs are combinational in the same cycle as `valid_i`. The stall output is registered.

Top module: `fence_pause_unit`

## Requirements
- R1: A word with `valid_i`=1, bits [6:0]=0001111 and bits [14:12]=000 that is not the pause word raises `fence_req_o` in the same cycle. Any other opcode or funct3 value, or `valid_i`=0, gives `fence_req_o`=0, `pause_o`=0, `pred_o`=0 and `succ_o`=0.
- R2: For a fence, `pred_o` comes from instruction bits [27:24] and `succ_o` from bits [23:20]. In each set, bit 3 is device input, bit 2 is device output, bit 1 is memory read and bit 0 is memory write. Bits [31:28], [19:15] and [11:7] do not change either set.
- R3: With `priv_i`=001 (supervisor) and `m_fiom_i`=1, in both sets a 1 in bit 3 also sets bit 1 and a 1 in bit 2 also sets bit 0.
- R4: With `priv_i`=000 (user), the promotion of R3 applies when `m_fiom_i` | `s_fiom_i` is 1.
- R5: With `priv_i`=101 (virtual supervisor) or 100 (virtual user), the promotion applies when `m_fiom_i` | `h_fiom_i` is 1.
- R6: With `priv_i`=011 (machine), or with the unused codes 010, 110 and 111, no promotion applies, whatever the enables.
- R7: The word 32'h0100000F with `valid_i`=1 raises `pause_o` and gives `fence_req_o`=0, `pred_o`=0 and `succ_o`=0. If any bit of the word differs, it is treated as an ordinary fence.
- R8: After an edge that accepts a pause, `stall_o` is 1 for exactly MAX_PAUSE_CYCLES cycles, as long as `mem_idle_i` stays 0.
- R9: An edge with `stall_o`=1, `mem_idle_i`=1 and no new pause ends the stall. A pause accepted while `mem_idle_i`=1 gives a stall of one cycle.
- R10: A pause accepted during a stall reloads the timer. The stall then lasts MAX_PAUSE_CYCLES cycles after that pause, and never longer.
- R11: While `rst_ni` is low and after its release, `stall_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| priv_i | input | 3 | Privilege mode: U=000, S=001, M=011, VU=100, VS=101 |
| m_fiom_i | input | 1 | Machine-level device-I/O-as-memory enable |
| s_fiom_i | input | 1 | Supervisor-level device-I/O-as-memory enable |
| h_fiom_i | input | 1 | Hypervisor-level device-I/O-as-memory enable |
| mem_idle_i | input | 1 | No memory transactions outstanding |
| fence_req_o | output | 1 | Fence request |
| pred_o | output | 4 | Effective predecessor set {I,O,R,W} |
| succ_o | output | 4 | Effective successor set {I,O,R,W} |
| pause_o | output | 1 | Pause hint decoded |
| stall_o | output | 1 | Retirement hold |

## Verification
The hardest case is a pause that lands while an earlier stall is still running. A restart that extends the stall instead of reloading it only shows up in the exact length of the combined stall. The bench therefore issues a second pause at a known sample inside a running stall and counts every stalled cycle from the first pause. The expected total is the elapsed count plus MAX_PAUSE_CYCLES. The promotion logic is covered by a full sweep of all eight mode codes against all eight enable combinations and all sixteen predecessor patterns.

// File: rtl/fence_pkg.sv
package fence_pkg;
  typedef enum logic [2:0] {
    PRIV_U  = 3'b000,
    PRIV_S  = 3'b001,
    PRIV_M  = 3'b011,
    PRIV_VU = 3'b100,
    PRIV_VS = 3'b101
  } priv_e;

  localparam logic [6:0]  OPC_ORDER  = 7'b0001111;
  localparam logic [2:0]  F3_FENCE   = 3'b000;
  localparam logic [31:0] PAUSE_WORD = 32'h0100000F;

  typedef struct packed {
    logic dev_in;
    logic dev_out;
    logic mem_rd;
    logic mem_wr;
  } ord_set_t;
endpackage

// File: rtl/fence_decode.sv
module fence_decode
  import fence_pkg::*;
(
  input  logic        valid_i,
  input  logic [31:0] instr_i,
  output logic        is_fence_o,
  output logic        is_pause_o,
  output ord_set_t    pred_raw_o,
  output ord_set_t    succ_raw_o
);
  logic opc_hit;

  assign opc_hit    = (instr_i[6:0] == OPC_ORDER) && (instr_i[14:12] == F3_FENCE);
  assign is_pause_o = valid_i && (instr_i == PAUSE_WORD);
  assign is_fence_o = valid_i && opc_hit && !is_pause_o;
  assign pred_raw_o = ord_set_t'(instr_i[27:24]);
  assign succ_raw_o = ord_set_t'(instr_i[23:20]);
endmodule

// File: rtl/fence_io_promote.sv
module fence_io_promote
  import fence_pkg::*;
#(
  parameter int NUM_SETS = 2
) (
  input  logic                     [2:0] priv_i,
  input  logic                           m_fiom_i,
  input  logic                           s_fiom_i,
  input  logic                           h_fiom_i,
  input  ord_set_t [NUM_SETS-1:0]        sets_i,
  output ord_set_t [NUM_SETS-1:0]        sets_o
);
  logic promote;

  always_comb begin
    unique case (priv_i)
      PRIV_S:           promote = m_fiom_i;
      PRIV_U:           promote = m_fiom_i | s_fiom_i;
      PRIV_VS, PRIV_VU: promote = m_fiom_i | h_fiom_i;
      default:          promote = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    always_comb begin
      sets_o[g]        = sets_i[g];
      sets_o[g].mem_rd = sets_i[g].mem_rd | (promote & sets_i[g].dev_in);
      sets_o[g].mem_wr = sets_i[g].mem_wr | (promote & sets_i[g].dev_out);
    end
  end
endmodule

// File: rtl/pause_stall_timer.sv
module pause_stall_timer #(
  parameter int MAX_PAUSE_CYCLES = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mem_idle_i,
  output logic stall_o
);
  localparam int CW = (MAX_PAUSE_CYCLES > 0) ? $clog2(MAX_PAUSE_CYCLES + 1) : 1;
  localparam logic [CW-1:0] LOAD    = CW'(MAX_PAUSE_CYCLES);
  localparam logic [CW:0]   RUN_LIM = (CW+1)'(MAX_PAUSE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= LOAD;  // restart, never accumulate
    else if (cnt_q != '0)      cnt_q <= mem_idle_i ? '0 : cnt_q - 1'b1;
  end

  assign stall_o = (cnt_q != '0);

  // run-length tracker for the bound check
  logic [CW:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_q <= '0;
    else if (start_i)            run_q <= '0;
    else if (stall_o && !(&run_q)) run_q <= run_q + 1'b1;
    else if (!stall_o)           run_q <= '0;
  end

  // R8
  stall_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (run_q < RUN_LIM));
  // R8
  pause_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (stall_o || MAX_PAUSE_CYCLES == 0));
  // R9
  idle_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && mem_idle_i && !start_i) |=> !stall_o);
  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (run_q == '0));
endmodule

// File: rtl/fence_pause_unit.sv
module fence_pause_unit
  import fence_pkg::*;
#(
  parameter int MAX_PAUSE_CYCLES = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] instr_i,
  input  logic [2:0]  priv_i,
  input  logic        m_fiom_i,
  input  logic        s_fiom_i,
  input  logic        h_fiom_i,
  input  logic        mem_idle_i,
  output logic        fence_req_o,
  output logic [3:0]  pred_o,
  output logic [3:0]  succ_o,
  output logic        pause_o,
  output logic        stall_o
);
  localparam int NSETS = 2;

  logic                   is_fence, is_pause;
  ord_set_t               pred_raw, succ_raw;
  ord_set_t [NSETS-1:0]   raw_sets, eff_sets;

  fence_decode i_decode (
    .valid_i    (valid_i),
    .instr_i    (instr_i),
    .is_fence_o (is_fence),
    .is_pause_o (is_pause),
    .pred_raw_o (pred_raw),
    .succ_raw_o (succ_raw)
  );

  assign raw_sets = {pred_raw, succ_raw};

  fence_io_promote #(.NUM_SETS(NSETS)) i_promote (
    .priv_i   (priv_i),
    .m_fiom_i (m_fiom_i),
    .s_fiom_i (s_fiom_i),
    .h_fiom_i (h_fiom_i),
    .sets_i   (raw_sets),
    .sets_o   (eff_sets)
  );

  pause_stall_timer #(.MAX_PAUSE_CYCLES(MAX_PAUSE_CYCLES)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (is_pause),
    .mem_idle_i (mem_idle_i),
    .stall_o    (stall_o)
  );

  assign fence_req_o = is_fence;
  assign pause_o     = is_pause;
  assign pred_o      = is_fence ? 4'(eff_sets[1]) : 4'b0;
  assign succ_o      = is_fence ? 4'(eff_sets[0]) : 4'b0;

  // R7
  pause_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> (!fence_req_o && pred_o == 4'b0 && succ_o == 4'b0));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!fence_req_o && !pause_o));
  // R6
  mach_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_req_o && priv_i == PRIV_M) |-> (pred_o == instr_i[27:24] && succ_o == instr_i[23:20]));
  // R3
  sup_promo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_req_o && priv_i == PRIV_S && m_fiom_i) |->
      ((!pred_o[3] || pred_o[1]) && (!pred_o[2] || pred_o[0]) &&
       (!succ_o[3] || succ_o[1]) && (!succ_o[2] || succ_o[0])));
endmodule

// File: tb/test_fence_pause_unit.sv
`timescale 1ns/1ps
module test_fence_pause_unit;
  localparam int MAXC = 12;
  localparam logic [31:0] PW = 32'h0100000F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [2:0]  priv = 3'b011;
  logic        mf = 1'b0, sf = 1'b0, hf = 1'b0;
  logic        idle = 1'b0;
  logic        freq, pz, stall;
  logic [3:0]  pred, succ;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  fence_pause_unit #(.MAX_PAUSE_CYCLES(MAXC)) i_fence_pause_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr), .priv_i(priv),
    .m_fiom_i(mf), .s_fiom_i(sf), .h_fiom_i(hf), .mem_idle_i(idle),
    .fence_req_o(freq), .pred_o(pred), .succ_o(succ), .pause_o(pz), .stall_o(stall)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit promo(input logic [2:0] m, input bit a, input bit b, input bit c);
    case (m)
      3'b001:         return a;
      3'b000:         return a | b;
      3'b101, 3'b100: return a | c;
      default:        return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] widen(input logic [3:0] s, input bit p);
    return {s[3], s[2], s[1] | (p & s[3]), s[0] | (p & s[2])};
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] fm, input logic [3:0] p, input logic [3:0] s,
                                     input logic [4:0] rs, input logic [2:0] f3, input logic [4:0] rd);
    return {fm, p, s, rs, f3, rd, 7'b0001111};
  endfunction

  task automatic drive(input bit v, input logic [31:0] w);
    @(negedge clk);
    valid = v; instr = w;
    #1;
  endtask

  int highs;

  initial begin
    // R11 reset state
    #5;
    chk("R11 stall in reset", int'(stall), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R11 stall after reset", int'(stall), 0);
    chk("R1 no req idle", int'(freq), 0);

    // R2..R6 sweep: every mode x every enable combo x every pred pattern
    for (int m = 0; m < 8; m++) begin
      for (int f = 0; f < 8; f++) begin
        for (int p = 0; p < 16; p++) begin
          logic [3:0] pp, ss;
          bit pr;
          pp = 4'(p); ss = 4'(15 - p);
          priv = 3'(m); mf = f[0]; sf = f[1]; hf = f[2];
          pr = promo(3'(m), f[0], f[1], f[2]);
          drive(1'b1, mk(4'(f), pp, ss, 5'(p), 3'b000, 5'(m)));
          chk("R1 fence req", int'(freq), 1);
          chk("R2-R6 pred R3 R4 R5 R6", int'(pred), int'(widen(pp, pr)));
          chk("R2 succ", int'(succ), int'(widen(ss, pr)));
        end
      end
    end

    priv = 3'b011; mf = 1; sf = 1; hf = 1;
    // R1 funct3 and opcode misses, invalid
    drive(1'b1, mk(4'h0, 4'hF, 4'hF, 5'd0, 3'b001, 5'd0));
    chk("R1 funct3 001", int'(freq), 0);
    chk("R1 funct3 pred", int'(pred), 0);
    drive(1'b1, mk(4'h0, 4'hF, 4'hF, 5'd0, 3'b000, 5'd0) ^ 32'h1);
    chk("R1 opcode miss", int'(freq), 0);
    drive(1'b0, mk(4'h0, 4'hF, 4'hF, 5'd0, 3'b000, 5'd0));
    chk("R1 invalid", int'(freq), 0);
    chk("R1 invalid succ", int'(succ), 0);
    // R2 full fence
    drive(1'b1, 32'h0FF0000F);
    chk("R2 full pred", int'(pred), 15);
    chk("R2 full succ", int'(succ), 15);
    // R7 exact pause and near misses
    drive(1'b1, PW);
    chk("R7 pause", int'(pz), 1);
    chk("R7 pause no req", int'(freq), 0);
    chk("R7 pause pred", int'(pred), 0);
    drive(1'b0, '0);
    for (int k = 0; k < 20; k++) @(negedge clk);
    drive(1'b1, PW | 32'h80);  // rd = x1
    chk("R7 near rd", int'(pz), 0);
    chk("R7 near rd req", int'(freq), 1);
    chk("R7 near rd pred", int'(pred), 1);
    drive(1'b1, PW | 32'h8000); // rs1 = x1
    chk("R7 near rs1", int'(pz), 0);
    drive(1'b1, PW | 32'h10000000); // fm != 0
    chk("R7 near fm", int'(pz), 0);
    chk("R11 no stall without pause", int'(stall), 0);
    drive(1'b0, PW);
    chk("R7 invalid pause", int'(pz), 0);
    @(negedge clk);
    chk("R7 invalid pause no stall", int'(stall), 0);

    // R8 full length with memory busy
    idle = 0;
    drive(1'b1, PW);
    highs = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); valid = 0;
      if (stall) highs++;
    end
    chk("R8 stall length", highs, MAXC);

    // R9 early end
    drive(1'b1, PW);
    @(negedge clk); valid = 0;
    @(negedge clk); @(negedge clk);
    chk("R9 stalling before idle", int'(stall), 1);
    idle = 1;
    @(negedge clk);
    chk("R9 ended by idle", int'(stall), 0);
    // R9 pause with idle already high
    drive(1'b1, PW);
    highs = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); valid = 0;
      if (stall) highs++;
    end
    chk("R9 idle pause length", highs, 1);
    idle = 0;

    // R10 restart inside stall
    drive(1'b1, PW);
    highs = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); valid = 0;
      if (stall) highs++;
      if (k == 4) begin
        valid = 1; instr = PW;
      end
    end
    chk("R10 restart length", highs, 5 + MAXC);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule